// File: doc/BRIEF.md
# Interval Timer Count Latch and Read-Back Path

This block sits between a byte-wide I/O bus and the three counting engines of an interval timer. It watches writes to the timer's control port and picks out two kinds of command. A single-counter latch freezes one counter's present value. A read-back command can freeze the count, the status or both for any chosen group of counters. Each counter keeps its own snapshot of the 16-bit count, a captured status byte and a byte pointer. Reads from a counter's data port are steered to the captured status, the frozen count or the live count, in that order of precedence.

The counting engines feed in their live 16-bit values, their programmed access and operating modes, their null-count flags and their OUT levels. A control write that selects a counter with a non-zero access field counts as reprogramming that counter. The block then drops that counter's pending captures and restarts its byte sequence. Read data is combinational while the read strobe is high. State moves on the clock edge that ends the read.

Top module: `pit_latch_readback`

## Requirements
- R1: The control port is at bus address 3. In a control write, bits 7:6 equal to 00, 01 or 10 address counter 0, 1 or 2, and 11 marks a read-back. A counter-addressed write with bits 5:4 equal to 00 latches exactly that counter's count. It latches no status.
- R2: A latch captures the live count on the clock edge that takes the control write. Later data-port reads of that counter return bytes of the captured value even when the live count changes.
- R3: While a counter holds a captured count that has not been fully read, further count latches to it are ignored. The bytes read are those of the first capture.
- R4: The byte order follows the counter's access mode: 01 gives the low byte only, 10 gives the high byte only, and 11 gives the low byte and then the high byte. A captured count is released after its last byte is read, so the next read returns the live count.
- R5: Data ports sit at address 0, 1 and 2 for counters 0, 1 and 2. Reads, latches and data-port writes aimed at other counters leave a counter's pending byte position and captured count unchanged.
- R6: In a read-back, bits 1, 2 and 3 select counters 0, 1 and 2. Unselected counters capture nothing, and a read-back that selects no counter has no effect.
- R7: A read-back with bit 4 equal to 0 captures the status byte of each selected counter. The byte is {OUT, null-count, access mode[1:0], operating mode[2:0], BCD}, with OUT taken at the capture edge. The next read of that counter returns the byte and releases it.
- R8: A read-back with bit 5 equal to 0 captures the count of each selected counter, under the same capture-once rule as R3.
- R9: When status and count are both captured, the first read returns status and the following reads return the count bytes in the order given by R4.
- R10: With nothing captured, reads return the live count. For access mode 11 the byte pointer alternates between low and high.
- R11: A control write that addresses a counter with bits 5:4 not equal to 00 releases that counter's captured status and count and resets its byte pointer to the low byte.
- R12: Reset clears all captures and byte pointers. The read data is 0 whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address: 0..2 data ports, 3 control port |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| live_count | input | NCNT*16 | Live count of each counter, counter 0 in the low bits |
| acc_mode | input | NCNT*2 | Programmed access mode of each counter |
| op_mode | input | NCNT*3 | Programmed operating mode of each counter |
| bcd_sel | input | NCNT | BCD counting flag of each counter |
| null_flag | input | NCNT | Null-count flag of each counter |
| out_level | input | NCNT | Present OUT level of each counter |

## Verification
The read path is tried with the three counters set to different access modes (word, low-only, high-only), so a wrong byte order or a wrong release point shows up as a different byte. Single-counter latches are compared with read-backs that capture count only, status only, both, or nothing. Each case tells apart whether the data came from the captured status, the frozen count or the live count. The live counts change after every capture, so a read of the live value cannot pass for a frozen one. Repeat latches, reads interleaved across counters, reprogramming midway through a two-byte read, OUT changing after a status capture, and reset with a capture pending are each tried directly.

// File: rtl/pit_lr_pkg.sv
// Package: shared constants and encodings for the timer latch/read-back path.
// Assumes byte-wide bus and 16-bit counts.
package pit_lr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    // Access-mode field of the control word / counter configuration.
    typedef enum logic [1:0] {
        ACC_CMD  = 2'b00,
        ACC_LO   = 2'b01,
        ACC_HI   = 2'b10,
        ACC_WORD = 2'b11
    } acc_mode_e;

    localparam logic [1:0] SEL_READBACK = 2'b11;
endpackage

// File: rtl/pit_lr_decode.sv
// Module: decodes control-port writes into per-counter capture and
// reprogram strobes. Assumes NCNT <= 3 (read-back select bits 3:1).
module pit_lr_decode
    import pit_lr_pkg::*;
#(
    parameter int NCNT      = 3,
    parameter int ADDR_W    = 2,
    parameter int CTRL_ADDR = 3
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [NCNT-1:0]   cap_cnt,
    output logic [NCNT-1:0]   cap_sts,
    output logic [NCNT-1:0]   reprog
);
    // Purpose: turn one control write into single-cycle strobes.
    always_comb begin
        cap_cnt = '0;
        cap_sts = '0;
        reprog  = '0;
        if (wr && addr == ADDR_W'(CTRL_ADDR)) begin
            if (wdata[7:6] == SEL_READBACK) begin
                for (int i = 0; i < NCNT; i++) begin
                    if (wdata[i+1]) begin
                        cap_cnt[i] = ~wdata[5];
                        cap_sts[i] = ~wdata[4];
                    end
                end
            end else begin
                for (int i = 0; i < NCNT; i++) begin
                    if (wdata[7:6] == 2'(i)) begin
                        if (wdata[5:4] == ACC_CMD) cap_cnt[i] = 1'b1;
                        else                       reprog[i]  = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/pit_lr_channel.sv
// Module: one counter's snapshot, status capture and byte pointer, plus
// the byte it presents to a data-port read. Assumes rd lasts one cycle.
module pit_lr_channel
    import pit_lr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_cnt,
    input  logic              cap_sts,
    input  logic              reprog,
    input  logic              rd,
    input  logic [CNT_W-1:0]  live,
    input  logic [1:0]        acc,
    input  logic [BYTE_W-1:0] sts_in,
    output logic [BYTE_W-1:0] rd_byte
);
    logic [CNT_W-1:0]  snap;
    logic              snap_v;
    logic [BYTE_W-1:0] sts;
    logic              sts_v;
    logic              hi_ptr;
    logic              take_hi;
    logic [CNT_W-1:0]  src;

    // Purpose: choose the byte a read of this counter returns.
    always_comb begin
        take_hi = (acc == ACC_HI) || (acc == ACC_WORD && hi_ptr);
        src     = snap_v ? snap : live;
        if (sts_v)        rd_byte = sts;
        else if (take_hi) rd_byte = src[CNT_W-1:BYTE_W];
        else              rd_byte = src[BYTE_W-1:0];
    end

    // Purpose: advance pointer, release and capture on each clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap   <= '0;
            snap_v <= 1'b0;
            sts    <= '0;
            sts_v  <= 1'b0;
            hi_ptr <= 1'b0;
        end else if (reprog) begin
            snap_v <= 1'b0;
            sts_v  <= 1'b0;
            hi_ptr <= 1'b0;
        end else begin
            if (rd) begin
                if (sts_v) begin
                    sts_v <= 1'b0;
                end else begin
                    if (acc == ACC_WORD) hi_ptr <= ~hi_ptr;
                    if (snap_v && (acc != ACC_WORD || hi_ptr)) snap_v <= 1'b0;
                end
            end
            if (cap_cnt && !snap_v) begin
                snap   <= live;
                snap_v <= 1'b1;
            end
            if (cap_sts && !sts_v) begin
                sts   <= sts_in;
                sts_v <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pit_latch_readback.sv
// Module: top of the timer latch/read-back path. Decodes control writes,
// holds one channel per counter and muxes the read byte onto the bus.
// Assumes single-cycle bus strobes, never read and write together.
module pit_latch_readback
    import pit_lr_pkg::*;
#(
    parameter int NCNT   = 3,
    parameter int ADDR_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [BYTE_W-1:0]      bus_wdata,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    output logic [BYTE_W-1:0]      bus_rdata,
    input  logic [NCNT*CNT_W-1:0]  live_count,
    input  logic [NCNT*2-1:0]      acc_mode,
    input  logic [NCNT*3-1:0]      op_mode,
    input  logic [NCNT-1:0]        bcd_sel,
    input  logic [NCNT-1:0]        null_flag,
    input  logic [NCNT-1:0]        out_level
);
    localparam int CTRL_ADDR = 3;

    logic [NCNT-1:0]   cap_cnt;
    logic [NCNT-1:0]   cap_sts;
    logic [NCNT-1:0]   reprog;
    logic [BYTE_W-1:0] rd_bytes [NCNT];

    pit_lr_decode #(.NCNT(NCNT), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_dec (
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .cap_cnt (cap_cnt),
        .cap_sts (cap_sts),
        .reprog  (reprog)
    );

    for (genvar g = 0; g < NCNT; g++) begin : g_ch
        logic [BYTE_W-1:0] sts_word;
        // Purpose: assemble this counter's status byte from its config.
        assign sts_word = {out_level[g], null_flag[g], acc_mode[2*g +: 2],
                           op_mode[3*g +: 3], bcd_sel[g]};

        pit_lr_channel u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .cap_cnt (cap_cnt[g]),
            .cap_sts (cap_sts[g]),
            .reprog  (reprog[g]),
            .rd      (bus_rd && bus_addr == ADDR_W'(g)),
            .live    (live_count[CNT_W*g +: CNT_W]),
            .acc     (acc_mode[2*g +: 2]),
            .sts_in  (sts_word),
            .rd_byte (rd_bytes[g])
        );
    end

    // Purpose: drive the addressed counter's byte onto the bus during a read.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCNT; i++) begin
            if (bus_rd && bus_addr == ADDR_W'(i)) bus_rdata = rd_bytes[i];
        end
    end
endmodule

// File: rtl/pit_lr_checker.sv
// Module: assertion checker for pit_latch_readback, attached by bind.
module pit_lr_checker #(
    parameter int NCNT   = 3,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_rdata,
    input logic [NCNT-1:0]   cap_cnt,
    input logic [NCNT-1:0]   cap_sts,
    input logic [NCNT-1:0]   reprog
);
    // R12: the read bus stays quiet outside a read.
    a_r12_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == 8'h00);

    // R1: with no write, the decoder issues no command.
    a_r1_no_cmd_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |-> (cap_cnt == '0 && cap_sts == '0 && reprog == '0));

    // R1: a counter latch hits exactly one counter and no status.
    a_r1_single_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(3) && bus_wdata[7:6] != 2'b11 &&
         bus_wdata[5:4] == 2'b00)
        |-> ($countones(cap_cnt) == 1 && cap_sts == '0 && reprog == '0));

    // R5: data-port writes never act as commands.
    a_r5_dataport_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != ADDR_W'(3))
        |-> (cap_cnt == '0 && cap_sts == '0 && reprog == '0));

    // R6: a read-back that selects no counter captures nothing.
    a_r6_empty_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(3) && bus_wdata[7:6] == 2'b11 &&
         bus_wdata[3:1] == 3'b000)
        |-> (cap_cnt == '0 && cap_sts == '0 && reprog == '0));

    // R6: a read-back never reprograms a counter.
    a_r6_readback_no_reprog: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(3) && bus_wdata[7:6] == 2'b11)
        |-> reprog == '0);
endmodule

bind pit_latch_readback pit_lr_checker #(.NCNT(NCNT), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .cap_cnt   (cap_cnt),
    .cap_sts   (cap_sts),
    .reprog    (reprog)
);

// File: tb/pit_latch_readback_test.sv
`timescale 1ns/1ps
// Bench: vector table walk followed by directed reset and corner tests.
// Counter 0 uses word access, counter 1 low-only, counter 2 high-only.
module pit_latch_readback_test;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_LV = 2'd2;
    localparam int NV = 49;
    // {requirement, op, address, value}: value is write data, expected
    // read byte, or a new live count for the addressed counter.
    localparam logic [23:0] VEC [NV] = '{
        {4'd10, OP_RD, 2'd0, 16'h0034},  // R10 live low
        {4'd10, OP_RD, 2'd0, 16'h0012},  // R10 live high
        {4'd1,  OP_WR, 2'd3, 16'h0000},  // R1 latch c0
        {4'd2,  OP_LV, 2'd0, 16'hAAB0},
        {4'd2,  OP_RD, 2'd0, 16'h0034},  // R2 frozen low
        {4'd5,  OP_RD, 2'd1, 16'h0078},  // R5 other counter
        {4'd5,  OP_WR, 2'd3, 16'h0040},  // latch c1
        {4'd5,  OP_LV, 2'd1, 16'h1111},
        {4'd5,  OP_RD, 2'd0, 16'h0012},  // R5 c0 high survives
        {4'd5,  OP_RD, 2'd1, 16'h0078},  // c1 frozen
        {4'd5,  OP_RD, 2'd1, 16'h0011},  // c1 released, live
        {4'd3,  OP_WR, 2'd3, 16'h0000},  // latch c0 = AAB0
        {4'd3,  OP_LV, 2'd0, 16'hBBCD},
        {4'd3,  OP_WR, 2'd3, 16'h0000},  // R3 repeat ignored
        {4'd3,  OP_RD, 2'd0, 16'h00B0},
        {4'd3,  OP_RD, 2'd0, 16'h00AA},
        {4'd3,  OP_RD, 2'd0, 16'h00CD},  // released
        {4'd3,  OP_RD, 2'd0, 16'h00BB},
        {4'd6,  OP_WR, 2'd3, 16'h00E8},  // status of c2 only
        {4'd7,  OP_RD, 2'd2, 16'h00A0},  // R7 status byte
        {4'd7,  OP_RD, 2'd2, 16'h009A},  // status released
        {4'd6,  OP_RD, 2'd0, 16'h00CD},  // R6 c0 unselected
        {4'd6,  OP_RD, 2'd0, 16'h00BB},
        {4'd9,  OP_WR, 2'd3, 16'h00C6},  // both, c0 and c1
        {4'd9,  OP_LV, 2'd0, 16'h0000},
        {4'd9,  OP_LV, 2'd1, 16'h0000},
        {4'd9,  OP_RD, 2'd0, 16'h00B4},  // R9 status first
        {4'd8,  OP_RD, 2'd0, 16'h00CD},  // R8 captured count
        {4'd8,  OP_RD, 2'd0, 16'h00BB},
        {4'd9,  OP_RD, 2'd1, 16'h0057},
        {4'd8,  OP_RD, 2'd1, 16'h0011},
        {4'd10, OP_RD, 2'd1, 16'h0000},
        {4'd8,  OP_WR, 2'd3, 16'h00D8},  // count of c2 only
        {4'd8,  OP_LV, 2'd2, 16'h1357},
        {4'd8,  OP_RD, 2'd2, 16'h009A},
        {4'd8,  OP_RD, 2'd2, 16'h0013},
        {4'd6,  OP_WR, 2'd3, 16'h00C0},  // R6 empty select
        {4'd6,  OP_RD, 2'd2, 16'h0013},
        {4'd11, OP_LV, 2'd0, 16'h4321},
        {4'd11, OP_WR, 2'd3, 16'h0000},
        {4'd11, OP_RD, 2'd0, 16'h0021},
        {4'd11, OP_WR, 2'd3, 16'h0034},  // R11 reprogram c0
        {4'd11, OP_LV, 2'd0, 16'h8765},
        {4'd11, OP_RD, 2'd0, 16'h0065},
        {4'd11, OP_RD, 2'd0, 16'h0087},
        {4'd4,  OP_WR, 2'd3, 16'h0080},  // latch c2 = 1357
        {4'd4,  OP_LV, 2'd2, 16'h0000},
        {4'd4,  OP_RD, 2'd2, 16'h0013},  // R4 high-only, one read
        {4'd4,  OP_RD, 2'd2, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [15:0] live [3];
    logic [2:0]  out_level = 3'b101;
    logic [47:0] live_count;
    int          n_cmp = 0;
    int          n_bad = 0;

    assign live_count = {live[2], live[1], live[0]};

    always #5 clk = ~clk;

    pit_latch_readback uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .live_count (live_count),
        .acc_mode   ({2'b10, 2'b01, 2'b11}),
        .op_mode    ({3'b000, 3'b011, 3'b010}),
        .bcd_sel    (3'b010),
        .null_flag  (3'b010),
        .out_level  (out_level)
    );

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2;
        check(bus_rdata, exp, tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        live[0] = 16'h1234; live[1] = 16'h5678; live[2] = 16'h9ABC;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_rdata, 8'h00, "R12 idle read data after reset");

        for (int v = 0; v < NV; v++) begin
            logic [3:0]  rq;
            logic [1:0]  op;
            logic [1:0]  ad;
            logic [15:0] vl;
            {rq, op, ad, vl} = VEC[v];
            case (op)
                OP_WR: do_wr(ad, vl[7:0]);
                OP_RD: do_rd(ad, vl[7:0], $sformatf("R%0d vector %0d", rq, v));
                default: begin
                    @(negedge clk);
                    live[ad] = vl;
                end
            endcase
        end

        // R7: OUT is taken when status is captured, not when read.
        do_wr(2'd3, 8'hE8);
        @(negedge clk);
        out_level = 3'b001;
        do_rd(2'd2, 8'hA0, "R7 OUT frozen at capture");
        out_level = 3'b101;

        // R12: reset drops a pending capture.
        do_wr(2'd3, 8'h40);
        @(negedge clk);
        live[1] = 16'h2222;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_rd(2'd1, 8'h22, "R12 reset clears capture");
        @(negedge clk);
        check(bus_rdata, 8'h00, "R12 idle read data");

        // R10: word-mode pointer restarts low after reset.
        live[0] = 16'hFE01;
        do_rd(2'd0, 8'h01, "R10 pointer low after reset");
        do_rd(2'd0, 8'hFE, "R10 pointer high");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule